// File: doc/BRIEF.md
# Doubleword Lane Shuffle Unit

This execute-stage block rearranges a 256-bit data vector of eight 32-bit lanes under the control of a 256-bit index vector. Each result lane is filled with whichever data lane the low three bits of the matching index lane name. Any data lane can feed any result lane. One data lane may feed several result lanes, and some data lanes may feed none.

The block also screens a few decoded encoding fields and rejects the operation when they are wrong. Operands arrive with a valid strobe. The result, a matching valid, a reject flag and a register-file write enable all appear one clock later. A rejected operation drives an all-zero result, so nothing partial reaches writeback. The lane selector is built in one of two forms, chosen by a parameter: a binary-index multiplexer or a one-hot AND-OR network.

Top module: `dword_lane_shuffle`

## Requirements
- R1: One cycle after an accepted operation, result lane i (bits 32*i+31 down to 32*i) equals the data lane numbered by `idx_vec[32*i+2 : 32*i]`. Lane 0 is the least significant.
- R2: Bits 31 to 3 of every index lane have no effect on the result.
- R3: Repeated index values are honoured. A data lane may appear in several result lanes, and others may appear in none.
- R4: When `dec_vlen256` is 0 on an input cycle, the next cycle shows `out_bad_op` = 1.
- R5: When `dec_wide` is 1 on an input cycle, the next cycle shows `out_bad_op` = 1.
- R6: The only accepted encoding is `dec_opcode` = 8'h36 with `dec_map` = 2'b10 (the three-byte 0F38 table) and `dec_pfx` = 2'b01 (implied 66 prefix). Any other value of these fields sets `out_bad_op` on the next cycle.
- R7: `out_valid` equals `in_valid` delayed by exactly one cycle. `out_bad_op` is 0 in any cycle where `out_valid` is 0.
- R8: Whenever `out_wr_en` is 0, including every reject, `out_result` is all zeros.
- R9: `out_wr_en` is 1 exactly when `out_valid` is 1 and `out_bad_op` is 0.
- R10: A synchronous active-high `rst` clears `out_valid`, `out_bad_op`, `out_wr_en` and `out_result` on the next clock edge.
- R11: `out_simd_fp_exc` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and decode fields are valid this cycle |
| idx_vec | input | 256 | Index vector, eight 32-bit lanes |
| src_vec | input | 256 | Data vector, eight 32-bit lanes |
| dec_opcode | input | 8 | Decoded opcode byte |
| dec_map | input | 2 | Opcode table select (2'b10 = 0F38) |
| dec_pfx | input | 2 | Implied prefix select (2'b01 = 66) |
| dec_vlen256 | input | 1 | Vector length field, 1 = 256 bits |
| dec_wide | input | 1 | Operand width field |
| out_valid | output | 1 | Registered result valid |
| out_bad_op | output | 1 | Invalid-opcode flag |
| out_result | output | 256 | Shuffled vector, or zero |
| out_wr_en | output | 1 | Destination register write enable |
| out_simd_fp_exc | output | 1 | SIMD floating-point exception, tied low |

## Verification
The only state in this block is one output register stage. A fault in it shows at the ports on the very cycle after the stimulus. A wrong select in one lane shows as a mismatched 32-bit slice. A stale valid or flag bit shows as a write enable that disagrees with the strobe. A missed zeroing shows as nonzero data beside a reject or idle cycle. The bench compares every output on every cycle against a behavioural model. So a wrong crossbar wire, a decode field compared against the wrong constant, or an index bit taken from the wrong position is reported within one clock of the first vector that exposes it.

// File: rtl/dls_pkg.sv
package dls_pkg;
   // Encoding values accepted by the decode screen
   localparam logic [7:0] DLS_OPC_SHUFFLE = 8'h36;
   localparam logic [1:0] DLS_MAP_0F38    = 2'b10;
   localparam logic [1:0] DLS_PFX_66      = 2'b01;

   // Lane selector implementation choices
   typedef enum logic [0:0] {
      XBAR_BINARY_MUX = 1'b0,
      XBAR_ONEHOT_OR  = 1'b1
   } xbar_style_e;

   // Registered output bundle
   typedef struct packed {
      logic valid;
      logic bad;
   } dls_status_t;
endpackage

// File: rtl/dls_enc_gate.sv
module dls_enc_gate
   import dls_pkg::*;
#(
   parameter logic [7:0] ACC_OPCODE = DLS_OPC_SHUFFLE,
   parameter logic [1:0] ACC_MAP    = DLS_MAP_0F38,
   parameter logic [1:0] ACC_PFX    = DLS_PFX_66
) (
   input  logic [7:0] opcode_i,
   input  logic [1:0] map_i,
   input  logic [1:0] pfx_i,
   input  logic       vlen256_i,
   input  logic       wide_i,
   output logic       accept_o
);
   logic opc_hit;
   logic map_hit;
   logic pfx_hit;
   logic len_ok;
   logic width_ok;

   always_comb begin
      opc_hit  = (opcode_i == ACC_OPCODE);
      map_hit  = (map_i == ACC_MAP);
      pfx_hit  = (pfx_i == ACC_PFX);
      len_ok   = vlen256_i;
      width_ok = ~wide_i;
      accept_o = opc_hit & map_hit & pfx_hit & len_ok & width_ok;
   end
endmodule

// File: rtl/dls_lane_pick.sv
module dls_lane_pick
   import dls_pkg::*;
#(
   parameter int          LANES  = 8,
   parameter int          LANE_W = 32,
   parameter xbar_style_e STYLE  = XBAR_BINARY_MUX,
   localparam int         SEL_W  = $clog2(LANES),
   localparam int         VEC_W  = LANES * LANE_W
) (
   input  logic [LANE_W-1:0] idx_lane_i,
   input  logic [VEC_W-1:0]  src_i,
   output logic [LANE_W-1:0] lane_o
);
   logic [SEL_W-1:0] sel;
   logic             idx_unused;

   assign sel        = idx_lane_i[SEL_W-1:0];
   assign idx_unused = ^idx_lane_i[LANE_W-1:SEL_W];

   generate
      if (STYLE == XBAR_BINARY_MUX) begin : g_mux
         always_comb begin
            lane_o = '0;
            for (int k = 0; k < LANES; k++) begin
               if (sel == k[SEL_W-1:0]) lane_o = src_i[k*LANE_W +: LANE_W];
            end
         end
      end else begin : g_onehot
         logic [LANES-1:0] hot;
         always_comb begin
            hot = '0;
            hot[sel] = 1'b1;
         end
         always_comb begin
            lane_o = '0;
            for (int k = 0; k < LANES; k++) begin
               lane_o = lane_o | (src_i[k*LANE_W +: LANE_W] & {LANE_W{hot[k]}});
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dword_lane_shuffle.sv
module dword_lane_shuffle
   import dls_pkg::*;
#(
   parameter int          LANES      = 8,
   parameter int          LANE_W     = 32,
   parameter xbar_style_e STYLE      = XBAR_BINARY_MUX,
   parameter logic [7:0]  ACC_OPCODE = DLS_OPC_SHUFFLE,
   parameter logic [1:0]  ACC_MAP    = DLS_MAP_0F38,
   parameter logic [1:0]  ACC_PFX    = DLS_PFX_66,
   localparam int         SEL_W      = $clog2(LANES),
   localparam int         VEC_W      = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] idx_vec,
   input  logic [VEC_W-1:0] src_vec,
   input  logic [7:0]       dec_opcode,
   input  logic [1:0]       dec_map,
   input  logic [1:0]       dec_pfx,
   input  logic             dec_vlen256,
   input  logic             dec_wide,
   output logic             out_valid,
   output logic             out_bad_op,
   output logic [VEC_W-1:0] out_result,
   output logic             out_wr_en,
   output logic             out_simd_fp_exc
);
   // Elaboration-time parameter checks
   generate
      if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
         $error("LANES must be a power of two of at least 2");
      end
      if (LANE_W <= SEL_W) begin : g_bad_width
         $error("LANE_W must exceed the index width");
      end
   endgenerate

   logic             accept;
   logic [VEC_W-1:0] xbar_out;
   dls_status_t      stat_q;
   logic [VEC_W-1:0] result_q;

   dls_enc_gate #(
      .ACC_OPCODE(ACC_OPCODE),
      .ACC_MAP   (ACC_MAP),
      .ACC_PFX   (ACC_PFX)
   ) u_gate (
      .opcode_i (dec_opcode),
      .map_i    (dec_map),
      .pfx_i    (dec_pfx),
      .vlen256_i(dec_vlen256),
      .wide_i   (dec_wide),
      .accept_o (accept)
   );

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         dls_lane_pick #(
            .LANES (LANES),
            .LANE_W(LANE_W),
            .STYLE (STYLE)
         ) u_pick (
            .idx_lane_i(idx_vec[g*LANE_W +: LANE_W]),
            .src_i     (src_vec),
            .lane_o    (xbar_out[g*LANE_W +: LANE_W])
         );
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         stat_q   <= '0;
         result_q <= '0;
      end else begin
         stat_q.valid <= in_valid;
         stat_q.bad   <= in_valid & ~accept;
         result_q     <= (in_valid & accept) ? xbar_out : '0;
      end
   end

   assign out_valid       = stat_q.valid;
   assign out_bad_op      = stat_q.bad;
   assign out_result      = result_q;
   assign out_wr_en       = stat_q.valid & ~stat_q.bad;
   assign out_simd_fp_exc = 1'b0;
endmodule

// File: rtl/dls_sva.sv
module dls_sva #(
   parameter int  LANES  = 8,
   parameter int  LANE_W = 32,
   localparam int SEL_W  = $clog2(LANES),
   localparam int VEC_W  = LANES * LANE_W
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [VEC_W-1:0] idx_vec,
   input logic [VEC_W-1:0] src_vec,
   input logic             dec_vlen256,
   input logic             dec_wide,
   input logic             out_valid,
   input logic             out_bad_op,
   input logic [VEC_W-1:0] out_result,
   input logic             out_wr_en
);
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_chk
         AST_LANE_COPY: assert property (@(posedge clk) disable iff (rst)
            out_wr_en |-> out_result[g*LANE_W +: LANE_W] ==
               $past(src_vec[idx_vec[g*LANE_W +: SEL_W]*LANE_W +: LANE_W])); // R1
      end
   endgenerate

   AST_VLEN_REJECT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !dec_vlen256) |=> out_bad_op); // R4

   AST_WIDE_REJECT: assert property (@(posedge clk) disable iff (rst)
      (in_valid && dec_wide) |=> out_bad_op); // R5

   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R7

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && !out_bad_op)); // R7

   AST_BAD_ZERO: assert property (@(posedge clk) disable iff (rst)
      !out_wr_en |-> (out_result == '0)); // R8

   AST_BAD_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
      out_bad_op |-> (out_valid && !out_wr_en)); // R9
endmodule

bind dword_lane_shuffle dls_sva #(
   .LANES (LANES),
   .LANE_W(LANE_W)
) u_sva (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .idx_vec    (idx_vec),
   .src_vec    (src_vec),
   .dec_vlen256(dec_vlen256),
   .dec_wide   (dec_wide),
   .out_valid  (out_valid),
   .out_bad_op (out_bad_op),
   .out_result (out_result),
   .out_wr_en  (out_wr_en)
);

// File: tb/dword_lane_shuffle_tb.sv
module dword_lane_shuffle_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 8;
   localparam int LW = 32;
   localparam int VW = NL * LW;

   logic          clk = 1'b0;
   logic          rst;
   logic          in_valid;
   logic [VW-1:0] idx_vec;
   logic [VW-1:0] src_vec;
   logic [7:0]    dec_opcode;
   logic [1:0]    dec_map;
   logic [1:0]    dec_pfx;
   logic          dec_vlen256;
   logic          dec_wide;
   logic          out_valid;
   logic          out_bad_op;
   logic [VW-1:0] out_result;
   logic          out_wr_en;
   logic          out_simd_fp_exc;

   int checks   = 0;
   int failures = 0;

   logic [VW-1:0] exp_res;
   logic          exp_valid;
   logic          exp_bad;

   always #(CLK_PERIOD/2) clk = ~clk;

   dword_lane_shuffle dut_i (
      .clk            (clk),
      .rst            (rst),
      .in_valid       (in_valid),
      .idx_vec        (idx_vec),
      .src_vec        (src_vec),
      .dec_opcode     (dec_opcode),
      .dec_map        (dec_map),
      .dec_pfx        (dec_pfx),
      .dec_vlen256    (dec_vlen256),
      .dec_wide       (dec_wide),
      .out_valid      (out_valid),
      .out_bad_op     (out_bad_op),
      .out_result     (out_result),
      .out_wr_en      (out_wr_en),
      .out_simd_fp_exc(out_simd_fp_exc)
   );

   task automatic chk(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural reference: compute what the registered outputs must be
   task automatic model(input logic v, input logic [VW-1:0] idx, input logic [VW-1:0] src,
                        input logic [7:0] opc, input logic [1:0] mp, input logic [1:0] pf,
                        input logic vl, input logic w);
      logic ok;
      ok = (opc == 8'h36) && (mp == 2'b10) && (pf == 2'b01) && vl && !w;
      exp_valid = v;
      exp_bad   = v && !ok;
      exp_res   = '0;
      if (v && ok) begin
         for (int i = 0; i < NL; i++) begin
            int pick;
            pick = int'(idx[i*LW +: 3]);
            exp_res[i*LW +: LW] = LW'(src >> (pick * LW));
         end
      end
   endtask

   task automatic step(input string req, input logic v, input logic [VW-1:0] idx,
                       input logic [VW-1:0] src, input logic [7:0] opc, input logic [1:0] mp,
                       input logic [1:0] pf, input logic vl, input logic w);
      @(negedge clk);
      in_valid = v; idx_vec = idx; src_vec = src; dec_opcode = opc;
      dec_map = mp; dec_pfx = pf; dec_vlen256 = vl; dec_wide = w;
      model(v, idx, src, opc, mp, pf, vl, w);
      @(posedge clk);
      #1;
      chk({req, " result"}, out_result, exp_res);
      chk("R7 valid", VW'(out_valid), VW'(exp_valid));
      chk({req, " bad_op"}, VW'(out_bad_op), VW'(exp_bad));
      chk("R9 wr_en", VW'(out_wr_en), VW'(exp_valid && !exp_bad));
      chk("R11 fp_exc", VW'(out_simd_fp_exc), '0);
   endtask

   function automatic logic [VW-1:0] mk_idx(input int a0, a1, a2, a3, a4, a5, a6, a7);
      logic [VW-1:0] r;
      r = '0;
      r[0*LW +: LW] = LW'(a0); r[1*LW +: LW] = LW'(a1);
      r[2*LW +: LW] = LW'(a2); r[3*LW +: LW] = LW'(a3);
      r[4*LW +: LW] = LW'(a4); r[5*LW +: LW] = LW'(a5);
      r[6*LW +: LW] = LW'(a6); r[7*LW +: LW] = LW'(a7);
      return r;
   endfunction

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] r;
      for (int i = 0; i < NL; i++) r[i*LW +: LW] = $urandom;
      return r;
   endfunction

   initial begin
      #(CLK_PERIOD * 20000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [VW-1:0] src;
      logic [VW-1:0] idx;
      void'($urandom(32'h5eed));
      rst = 1'b1; in_valid = 1'b0; idx_vec = '0; src_vec = '0;
      dec_opcode = 8'h36; dec_map = 2'b10; dec_pfx = 2'b01;
      dec_vlen256 = 1'b1; dec_wide = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R10: reset state
      chk("R10 valid", VW'(out_valid), '0);
      chk("R10 bad", VW'(out_bad_op), '0);
      chk("R10 wr_en", VW'(out_wr_en), '0);
      chk("R10 result", out_result, '0);
      @(negedge clk);
      rst = 1'b0;

      src = rnd_vec();
      step("R1 identity", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b10, 2'b01, 1, 0);
      step("R1 reverse", 1, mk_idx(7,6,5,4,3,2,1,0), src, 8'h36, 2'b10, 2'b01, 1, 0);
      step("R1 rotate", 1, mk_idx(3,4,5,6,7,0,1,2), src, 8'h36, 2'b10, 2'b01, 1, 0);
      step("R3 broadcast", 1, mk_idx(5,5,5,5,5,5,5,5), src, 8'h36, 2'b10, 2'b01, 1, 0);
      step("R3 pairs", 1, mk_idx(1,1,6,6,0,0,1,6), src, 8'h36, 2'b10, 2'b01, 1, 0);
      step("R2 high bits", 1,
           mk_idx(32'hFFFFFFF8 | 2, 32'h80000008 | 7, 32'hDEADBEE8, 32'h00000010 | 3,
                  32'h7FFFFFF8 | 1, 32'hAAAAAAA8 | 6, 32'h55555558 | 4, 32'hFFFFFFFF),
           src, 8'h36, 2'b10, 2'b01, 1, 0);
      step("R4 vlen zero", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b10, 2'b01, 0, 0);
      step("R5 wide set", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b10, 2'b01, 1, 1);
      step("R6 opcode", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h37, 2'b10, 2'b01, 1, 0);
      step("R6 opcode16", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h16, 2'b10, 2'b01, 1, 0);
      step("R6 map", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b01, 2'b01, 1, 0);
      step("R6 map3", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b11, 2'b01, 1, 0);
      step("R6 prefix", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b10, 2'b00, 1, 0);
      step("R6 prefix2", 1, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b10, 2'b10, 1, 0);
      step("R8 idle", 0, mk_idx(0,1,2,3,4,5,6,7), src, 8'h36, 2'b10, 2'b01, 1, 0);
      step("R8 idle bad", 0, mk_idx(0,1,2,3,4,5,6,7), src, 8'h00, 2'b00, 2'b00, 0, 1);
      step("R1 after idle", 1, mk_idx(2,0,7,1,3,3,4,6), rnd_vec(), 8'h36, 2'b10, 2'b01, 1, 0);

      for (int n = 0; n < 300; n++) begin
         logic v;
         logic good;
         v    = ($urandom % 5) != 0;
         good = ($urandom % 4) != 0;
         idx  = rnd_vec();
         if (good)
            step("R1 random", v, idx, rnd_vec(), 8'h36, 2'b10, 2'b01, 1, 0);
         else
            step("R6 random", v, idx, rnd_vec(), 8'($urandom), 2'($urandom), 2'($urandom),
                 1'($urandom), 1'($urandom));
      end

      // R10: reset during traffic
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b1;
      @(posedge clk);
      #1;
      chk("R10 valid mid", VW'(out_valid), '0);
      chk("R10 result mid", out_result, '0);
      @(negedge clk);
      rst = 1'b0; in_valid = 1'b0;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule